// File: doc/BRIEF.md
# Signed Multiply-Accumulate Array Sequencer

This block walks two arrays of signed elements held in byte-addressed memory. It multiplies each pair of matching elements and adds the products into a 96-bit running sum kept as three 32-bit words. A caller loads two start addresses, an element count, an element width and the starting sum, then pulses `start`. The engine fetches one element from each array per step over a single-outstanding request/valid read port. When the count is used up it reports the advanced addresses, a zero count, the final sum and two status flags.

Each 64-bit signed product is folded into the sum one word at a time. The low word's carry feeds the middle word, and the middle word's carry feeds the high word. The high word also receives the product's sign extension. At the end, the upper half of the high word is overwritten with copies of its bit 15. The overflow flag then reports whether the high word still holds anything beyond a sign.

Top module: `mac_stream_engine`

## Requirements
- R1: After reset `busy`, `done`, `rd_req`, both flags and all address, count and sum outputs are zero.
- R2: A `start` with `count_in` equal to zero issues no read. One cycle later `done` rises with the pointers unchanged and the low and middle words equal to their initial values. The high word and the flags are derived from the initial high word as in R7 and R8.
- R3: Each element step issues exactly two reads. The first array is read at its pointer first, then the second array. `rd_size` carries the width code: 0 = byte, 1 = halfword, 2 = word. A `elem_size` code of 3 behaves as a word.
- R4: After each completed fetch, the pointer used for that fetch advances by 1, 2 or 4 bytes, and the other pointer holds. After N elements each pointer equals its start plus N times the element width.
- R5: A fetched element is taken from the low 8, 16 or 32 bits of `rd_data` and is sign-extended to 32 bits. The remaining upper bits of `rd_data` are ignored.
- R6: Each product is the signed 64-bit product of the two extended elements. It is added into {high, middle, low} with carry from word to word, and the product's sign extension is added into the high word. The result equals a 96-bit two's-complement sum.
- R7: On finishing, bits 31:16 of the high word become all ones if bit 15 is 1 and all zeros otherwise.
- R8: At `done`, `flag_sign` equals bit 31 of the final high word. `flag_ovf` is 1 exactly when that word is neither 0x00000000 nor 0xFFFFFFFF.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after the accepted `start` through the `done` cycle. `count_out` is zero at `done`.
- R10: `rd_req` is a one-cycle strobe, and no further request is made until `rd_valid` answers it. `rd_valid` arriving while no read is awaited, including while idle, changes nothing.
- R11: A `start` while `busy` is high is ignored, and the running operation completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| ptr_a_in | input | ADDR_W | Start address of the first array |
| ptr_b_in | input | ADDR_W | Start address of the second array |
| count_in | input | CNT_W | Number of element pairs |
| elem_size | input | 2 | Element width code (0 byte, 1 half, 2/3 word) |
| sum_lo_in | input | 32 | Initial low sum word |
| sum_mid_in | input | 32 | Initial middle sum word |
| sum_hi_in | input | 32 | Initial high sum word |
| rd_req | output | 1 | Read request strobe |
| rd_addr | output | ADDR_W | Read byte address |
| rd_size | output | 2 | Read width code |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data, element in the low bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ptr_a_out | output | ADDR_W | Current first-array address |
| ptr_b_out | output | ADDR_W | Current second-array address |
| count_out | output | CNT_W | Remaining element count |
| sum_lo_out | output | 32 | Low sum word |
| sum_mid_out | output | 32 | Middle sum word |
| sum_hi_out | output | 32 | High sum word |
| flag_sign | output | 1 | Sign of the final high word |
| flag_ovf | output | 1 | Final high word holds more than a sign |

## Verification
The last accumulate and the final fold happen in the same clock step. The carry out of the final product can therefore ripple into the high word and push it across bit 15 in the very cycle the fold reads that bit. A word-width case provokes this: it starts from low and middle words of all ones and a high word of 0x00007FFF, so that a small positive product carries through both lower words. The bench judges the result against a plain 96-bit signed reference sum folded after the loop, which expects 0xFFFF8000 with both flags set.

// File: rtl/mse_pkg.sv
package mse_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int PROD_W = 2 * WORD_W;

  typedef enum logic [1:0] {
    ESZ_BYTE = 2'd0,
    ESZ_HALF = 2'd1,
    ESZ_WORD = 2'd2
  } esz_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_A,
    ST_WAIT_A,
    ST_REQ_B,
    ST_WAIT_B,
    ST_MAC,
    ST_FIN
  } seq_st_t;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] mid;
    logic [WORD_W-1:0] lo;
  } sum3_t;

  function automatic esz_t norm_size(input logic [1:0] code);
    return (code == 2'd3) ? ESZ_WORD : esz_t'(code);
  endfunction

  function automatic logic [2:0] size_bytes(input esz_t s);
    case (s)
      ESZ_BYTE: return 3'd1;
      ESZ_HALF: return 3'd2;
      default:  return 3'd4;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] sext_elem(input logic [WORD_W-1:0] d, input esz_t s);
    case (s)
      ESZ_BYTE: return {{(WORD_W-8){d[7]}}, d[7:0]};
      ESZ_HALF: return {{(WORD_W-16){d[15]}}, d[15:0]};
      default:  return d;
    endcase
  endfunction

  // word-serial add of a signed product with carry chaining
  function automatic sum3_t mac_add(input sum3_t acc, input logic [PROD_W-1:0] prod);
    logic [WORD_W:0] t_lo;
    logic [WORD_W:0] t_mid;
    sum3_t r;
    t_lo  = {1'b0, acc.lo} + {1'b0, prod[WORD_W-1:0]};
    t_mid = {1'b0, acc.mid} + {1'b0, prod[PROD_W-1:WORD_W]} + {{WORD_W{1'b0}}, t_lo[WORD_W]};
    r.lo  = t_lo[WORD_W-1:0];
    r.mid = t_mid[WORD_W-1:0];
    r.hi  = acc.hi + {WORD_W{prod[PROD_W-1]}} + {{(WORD_W-1){1'b0}}, t_mid[WORD_W]};
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] fold_hi(input logic [WORD_W-1:0] hi);
    return {{(WORD_W-HALF_W){hi[HALF_W-1]}}, hi[HALF_W-1:0]};
  endfunction

  function automatic logic ovf_of(input logic [WORD_W-1:0] hi);
    return (hi != '0) && (hi != '1);
  endfunction
endpackage

// File: rtl/mse_seq.sv
module mse_seq
  import mse_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic init_zero,
  input  logic cnt_last,
  input  logic rd_valid,
  output logic busy,
  output logic done,
  output logic rd_req,
  output logic sel_b,
  output logic ev_load,
  output logic ev_zero,
  output logic ev_fetch_a,
  output logic ev_fetch_b,
  output logic ev_acc,
  output logic ev_last
);
  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (start) st_d = init_zero ? ST_FIN : ST_REQ_A;
      ST_REQ_A:  st_d = ST_WAIT_A;
      ST_WAIT_A: if (rd_valid) st_d = ST_REQ_B;
      ST_REQ_B:  st_d = ST_WAIT_B;
      ST_WAIT_B: if (rd_valid) st_d = ST_MAC;
      ST_MAC:    st_d = cnt_last ? ST_FIN : ST_REQ_A;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_FIN);
  assign rd_req     = (st_q == ST_REQ_A) || (st_q == ST_REQ_B);
  assign sel_b      = (st_q == ST_REQ_B);
  assign ev_load    = (st_q == ST_IDLE) && start;
  assign ev_zero    = ev_load && init_zero;
  assign ev_fetch_a = (st_q == ST_WAIT_A) && rd_valid;
  assign ev_fetch_b = (st_q == ST_WAIT_B) && rd_valid;
  assign ev_acc     = (st_q == ST_MAC);
  assign ev_last    = ev_acc && cnt_last;
endmodule

// File: rtl/mse_ptrs.sv
module mse_ptrs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] init_a,
  input  logic [ADDR_W-1:0] init_b,
  input  logic              adv_a,
  input  logic              adv_b,
  input  logic [2:0]        step,
  output logic [ADDR_W-1:0] ptr_a,
  output logic [ADDR_W-1:0] ptr_b
);
  localparam int LANES = 2;

  logic [LANES-1:0][ADDR_W-1:0] init_v;
  logic [LANES-1:0][ADDR_W-1:0] ptr_v;
  logic [LANES-1:0]             adv_v;
  logic [ADDR_W-1:0]            step_w;

  assign init_v = {init_b, init_a};
  assign adv_v  = {adv_b, adv_a};
  assign step_w = {{(ADDR_W-3){1'b0}}, step};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)        ptr_v[l] <= '0;
      else if (load)     ptr_v[l] <= init_v[l];
      else if (adv_v[l]) ptr_v[l] <= ptr_v[l] + step_w;
    end
  end

  assign ptr_a = ptr_v[0];
  assign ptr_b = ptr_v[1];
endmodule

// File: rtl/mse_accum.sv
module mse_accum
  import mse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              zero_fin,
  input  sum3_t             init,
  input  logic              acc_en,
  input  logic              acc_last,
  input  logic [PROD_W-1:0] prod,
  output sum3_t             sum,
  output logic              flag_sign,
  output logic              flag_ovf
);
  sum3_t             nxt;
  logic [WORD_W-1:0] init_fold;
  logic [WORD_W-1:0] nxt_fold;

  assign nxt       = mac_add(sum, prod);
  assign init_fold = fold_hi(init.hi);
  assign nxt_fold  = fold_hi(nxt.hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum       <= '0;
      flag_sign <= 1'b0;
      flag_ovf  <= 1'b0;
    end else if (load) begin
      sum.lo    <= init.lo;
      sum.mid   <= init.mid;
      sum.hi    <= zero_fin ? init_fold : init.hi;
      flag_sign <= zero_fin ? init_fold[WORD_W-1] : 1'b0;
      flag_ovf  <= zero_fin ? ovf_of(init_fold) : 1'b0;
    end else if (acc_en) begin
      sum.lo  <= nxt.lo;
      sum.mid <= nxt.mid;
      sum.hi  <= acc_last ? nxt_fold : nxt.hi;
      if (acc_last) begin
        flag_sign <= nxt_fold[WORD_W-1];
        flag_ovf  <= ovf_of(nxt_fold);
      end
    end
  end
endmodule

// File: rtl/mac_stream_engine.sv
module mac_stream_engine
  import mse_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ptr_a_in,
  input  logic [ADDR_W-1:0] ptr_b_in,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [1:0]        elem_size,
  input  logic [31:0]       sum_lo_in,
  input  logic [31:0]       sum_mid_in,
  input  logic [31:0]       sum_hi_in,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_size,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ptr_a_out,
  output logic [ADDR_W-1:0] ptr_b_out,
  output logic [CNT_W-1:0]  count_out,
  output logic [31:0]       sum_lo_out,
  output logic [31:0]       sum_mid_out,
  output logic [31:0]       sum_hi_out,
  output logic              flag_sign,
  output logic              flag_ovf
);
  // named internal events, also observed by the checker
  logic ev_load, ev_zero, ev_fetch_a, ev_fetch_b, ev_acc, ev_last;
  logic sel_b;
  logic cnt_last, init_zero;
  logic [2:0] step_bytes;

  logic [CNT_W-1:0]  cnt_q;
  esz_t              size_q;
  logic [WORD_W-1:0] op_a_q, op_b_q;
  logic [PROD_W-1:0] prod;
  sum3_t             init_sum, sum_q;

  assign init_zero  = (count_in == '0);
  assign cnt_last   = (cnt_q == CNT_W'(1));
  assign step_bytes = size_bytes(size_q);
  assign prod       = PROD_W'($signed(op_a_q)) * PROD_W'($signed(op_b_q));
  assign init_sum   = '{hi: sum_hi_in, mid: sum_mid_in, lo: sum_lo_in};

  mse_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .init_zero  (init_zero),
    .cnt_last   (cnt_last),
    .rd_valid   (rd_valid),
    .busy       (busy),
    .done       (done),
    .rd_req     (rd_req),
    .sel_b      (sel_b),
    .ev_load    (ev_load),
    .ev_zero    (ev_zero),
    .ev_fetch_a (ev_fetch_a),
    .ev_fetch_b (ev_fetch_b),
    .ev_acc     (ev_acc),
    .ev_last    (ev_last)
  );

  mse_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ev_load),
    .init_a (ptr_a_in),
    .init_b (ptr_b_in),
    .adv_a  (ev_fetch_a),
    .adv_b  (ev_fetch_b),
    .step   (step_bytes),
    .ptr_a  (ptr_a_out),
    .ptr_b  (ptr_b_out)
  );

  mse_accum u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_load),
    .zero_fin  (ev_zero),
    .init      (init_sum),
    .acc_en    (ev_acc),
    .acc_last  (ev_last),
    .prod      (prod),
    .sum       (sum_q),
    .flag_sign (flag_sign),
    .flag_ovf  (flag_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      size_q <= ESZ_BYTE;
      op_a_q <= '0;
      op_b_q <= '0;
    end else begin
      if (ev_load) begin
        cnt_q  <= count_in;
        size_q <= norm_size(elem_size);
      end else if (ev_acc) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (ev_fetch_a) op_a_q <= sext_elem(rd_data, size_q);
      if (ev_fetch_b) op_b_q <= sext_elem(rd_data, size_q);
    end
  end

  assign rd_addr     = sel_b ? ptr_b_out : ptr_a_out;
  assign rd_size     = size_q;
  assign count_out   = cnt_q;
  assign sum_lo_out  = sum_q.lo;
  assign sum_mid_out = sum_q.mid;
  assign sum_hi_out  = sum_q.hi;
endmodule

// File: rtl/mse_checker.sv
module mse_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rd_req,
  input logic [ADDR_W-1:0] ptr_a_out,
  input logic [ADDR_W-1:0] ptr_b_out,
  input logic [CNT_W-1:0]  count_out,
  input logic [31:0]       sum_hi_out,
  input logic              flag_sign,
  input logic              flag_ovf,
  input logic              ev_fetch_a,
  input logic              ev_fetch_b,
  input logic [2:0]        step_bytes
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_count_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count_out == '0));
  assert_fold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sum_hi_out[31:16] == {16{sum_hi_out[15]}}));
  assert_sign_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_sign == sum_hi_out[31]));
  assert_ovf_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_ovf == ((sum_hi_out != 32'h0) && (sum_hi_out != 32'hFFFF_FFFF))));
  assert_single_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);
  assert_ptr_a_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_a |=> (ptr_a_out == $past(ptr_a_out) + ADDR_W'($past(step_bytes))));
  assert_ptr_b_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_a |=> $stable(ptr_b_out));
  assert_ptr_b_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_b |=> (ptr_b_out == $past(ptr_b_out) + ADDR_W'($past(step_bytes))));
endmodule

bind mac_stream_engine mse_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mse_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .rd_req     (rd_req),
  .ptr_a_out  (ptr_a_out),
  .ptr_b_out  (ptr_b_out),
  .count_out  (count_out),
  .sum_hi_out (sum_hi_out),
  .flag_sign  (flag_sign),
  .flag_ovf   (flag_ovf),
  .ev_fetch_a (ev_fetch_a),
  .ev_fetch_b (ev_fetch_b),
  .step_bytes (step_bytes)
);

// File: tb/mac_stream_engine_bench.sv
`timescale 1ns/1ps
module mac_stream_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ptr_a_in = '0, ptr_b_in = '0, count_in = '0;
  logic [1:0]  elem_size = '0;
  logic [31:0] sum_lo_in = '0, sum_mid_in = '0, sum_hi_in = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic [1:0]  rd_size;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        busy, done, flag_sign, flag_ovf;
  logic [31:0] ptr_a_out, ptr_b_out, count_out, sum_lo_out, sum_mid_out, sum_hi_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0]  mem [0:1023];
  logic [31:0] log_addr [0:63];
  logic [1:0]  log_size [0:63];
  int          log_n = 0;
  int          lat = 1;
  bit          spur = 0;

  always #2.5 clk = ~clk;

  mac_stream_engine u_mac_stream_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ptr_a_in(ptr_a_in), .ptr_b_in(ptr_b_in), .count_in(count_in), .elem_size(elem_size),
    .sum_lo_in(sum_lo_in), .sum_mid_in(sum_mid_in), .sum_hi_in(sum_hi_in),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .ptr_a_out(ptr_a_out), .ptr_b_out(ptr_b_out), .count_out(count_out),
    .sum_lo_out(sum_lo_out), .sum_mid_out(sum_mid_out), .sum_hi_out(sum_hi_out),
    .flag_sign(flag_sign), .flag_ovf(flag_ovf)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {mem[(a+3) & 1023], mem[(a+2) & 1023], mem[(a+1) & 1023], mem[a & 1023]};
  endfunction

  // memory responder: one answer per request, after lat cycles
  initial begin
    @(negedge clk);
    forever begin
      if (rd_req) begin
        if (log_n < 64) begin
          log_addr[log_n] = rd_addr;
          log_size[log_n] = rd_size;
        end
        log_n++;
        if (spur) begin
          rd_valid = 1'b1;
          rd_data  = 32'hDEAD_BEEF;
        end
        @(negedge clk);
        rd_valid = 1'b0;
        repeat (lat - 1) @(negedge clk);
        rd_valid = 1'b1;
        rd_data  = word_at(log_addr[(log_n - 1) & 63]);
        @(negedge clk);
        rd_valid = 1'b0;
        rd_data  = 32'h5A5A_5A5A;
      end else begin
        @(negedge clk);
      end
    end
  end

  // reference element read: sign-extended per width code
  function automatic int ref_elem(input logic [31:0] a, input int sz);
    logic [31:0] w;
    w = word_at(a);
    if (sz == 0) return int'($signed(w[7:0]));
    if (sz == 1) return int'($signed(w[15:0]));
    return int'($signed(w));
  endfunction

  task automatic fill_mem(input int seed);
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 73 + seed * 29 + 5) & 255);
  endtask

  task automatic run_case(input string name, input string sum_req,
                          input logic [31:0] pa, input logic [31:0] pb, input int n,
                          input logic [1:0] sz, input logic [31:0] lo, input logic [31:0] mid,
                          input logic [31:0] hi, input int latency, input bit spurious,
                          input bit restart);
    logic signed [95:0] acc;
    logic [31:0] ehi;
    int bytes, esz, cyc;
    bit busy_bad, ord_bad;
    esz   = (sz == 2'd3) ? 2 : int'(sz);
    bytes = (esz == 0) ? 1 : (esz == 1) ? 2 : 4;
    acc = {hi, mid, lo};
    for (int i = 0; i < n; i++)
      acc = acc + 96'(longint'(ref_elem(pa + i * bytes, esz)) * longint'(ref_elem(pb + i * bytes, esz)));
    ehi = acc[95:64];
    ehi = ehi[15] ? {16'hFFFF, ehi[15:0]} : {16'h0000, ehi[15:0]};

    lat = latency; spur = spurious; log_n = 0;
    ptr_a_in = pa; ptr_b_in = pb; count_in = n; elem_size = sz;
    sum_lo_in = lo; sum_mid_in = mid; sum_hi_in = hi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; busy_bad = 0;
    while (!done && cyc < 3000) begin
      if (!busy) busy_bad = 1;
      if (restart && cyc == 6) begin
        start = 1'b1; count_in = 0; ptr_a_in = 32'h300; sum_hi_in = 32'h1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (!done) begin
      checks++; failures++;
      $display("FAIL R9 %s: no done within limit, actual=0 expected=1", name);
      return;
    end
    chk("R9", {name, " busy through run"}, {31'b0, busy_bad | ~busy}, 32'd0);
    chk("R9", {name, " count at done"}, count_out, 32'd0);
    chk("R4", {name, " ptr_a final"}, ptr_a_out, pa + n * bytes);
    chk("R4", {name, " ptr_b final"}, ptr_b_out, pb + n * bytes);
    chk(sum_req, {name, " sum low"}, sum_lo_out, acc[31:0]);
    chk(sum_req, {name, " sum mid"}, sum_mid_out, acc[63:32]);
    chk("R7", {name, " folded high"}, sum_hi_out, ehi);
    chk("R8", {name, " sign flag"}, {31'b0, flag_sign}, {31'b0, ehi[31]});
    chk("R8", {name, " ovf flag"}, {31'b0, flag_ovf},
        {31'b0, (ehi != 32'h0) && (ehi != 32'hFFFF_FFFF)});
    chk("R3", {name, " request count"}, log_n, 2 * n);
    ord_bad = 0;
    for (int i = 0; i < 2 * n && i < 64; i++) begin
      if (log_addr[i] !== ((i % 2 == 0) ? pa : pb) + (i / 2) * bytes) ord_bad = 1;
      if (log_size[i] !== 2'(esz)) ord_bad = 1;
    end
    chk("R3", {name, " request order and size"}, {31'b0, ord_bad}, 32'd0);
    @(negedge clk);
    chk("R9", {name, " done one cycle"}, {31'b0, done}, 32'd0);
    chk("R9", {name, " idle after done"}, {31'b0, busy}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1", "busy after reset", {31'b0, busy}, 32'd0);
    chk("R1", "done after reset", {31'b0, done}, 32'd0);
    chk("R1", "rd_req after reset", {31'b0, rd_req}, 32'd0);
    chk("R1", "flags after reset", {30'b0, flag_sign, flag_ovf}, 32'd0);
    chk("R1", "sum after reset", sum_lo_out | sum_mid_out | sum_hi_out, 32'd0);
    chk("R1", "ptrs and count after reset", ptr_a_out | ptr_b_out | count_out, 32'd0);
  endtask

  task automatic t_idle_valid;
    rd_valid = 1'b1; rd_data = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd_valid = 1'b0;
    @(negedge clk);
    chk("R10", "idle valid leaves busy low", {31'b0, busy}, 32'd0);
    chk("R10", "idle valid makes no request", log_n, 0);
    chk("R10", "idle valid leaves sum", sum_lo_out | sum_hi_out, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    fill_mem(1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_valid();
    // R5 byte elements, upper bits of rd_data are unrelated memory
    run_case("byte", "R5", 32'h40, 32'h180, 5, 2'd0, 32'h1000, 32'h0, 32'h0, 1, 0, 0);
    fill_mem(2);
    run_case("half", "R5", 32'h42, 32'h1A0, 3, 2'd1, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, 0, 0);
    // R6 carry ripple into high word across bit 15 in the final step
    fill_mem(3);
    mem[32'h80] = 8'h03; mem[32'h81] = 8'h00; mem[32'h82] = 8'h00; mem[32'h83] = 8'h00;
    mem[32'h200] = 8'h02; mem[32'h201] = 8'h00; mem[32'h202] = 8'h00; mem[32'h203] = 8'h00;
    run_case("carry", "R6", 32'h80, 32'h200, 1, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_7FFF, 3, 0, 0);
    fill_mem(4);
    run_case("word", "R6", 32'h100, 32'h240, 4, 2'd2, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_0123, 1, 0, 0);
    // R2 zero count: no reads, fold applied to initial high word
    run_case("zero_ovf", "R2", 32'h10, 32'h20, 0, 2'd0, 32'hAAAA_0001, 32'h5555_0002, 32'h1234_8001, 1, 0, 0);
    run_case("zero_clean", "R2", 32'h14, 32'h24, 0, 2'd1, 32'h1, 32'h2, 32'hABCD_FFFF, 1, 0, 0);
    run_case("zero_zero", "R2", 32'h18, 32'h28, 0, 2'd2, 32'h3, 32'h4, 32'hFFFF_0000, 1, 0, 0);
    // R10 stray valid during request cycles; code 3 as word (R3)
    fill_mem(5);
    run_case("stray_valid", "R10", 32'h60, 32'h2C0, 3, 2'd3, 32'h0, 32'h0, 32'h0, 2, 1, 0);
    // R11 start while busy ignored
    fill_mem(6);
    run_case("restart", "R11", 32'h50, 32'h250, 3, 2'd1, 32'h77, 32'h0, 32'h0, 2, 0, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule